// File: doc/BRIEF.md
# Packed Saturating Adder

This unit performs lane-wise saturating addition on a 32-bit datapath. Two 32-bit sources are split either into four signed byte lanes or into two signed halfword lanes. Each lane is summed on its own, with no carry crossing into a neighbouring lane. Any lane whose true sum leaves its signed range is clamped to the nearest limit. Two further operations clamp the first source, taken as a signed 32-bit integer, to a selectable bit width, in either a signed or an unsigned form.

The operation is chosen per cycle by a 2-bit select. The result and a 4-bit per-lane clamp indicator are computed combinationally and captured in one output register. A new operation can therefore be issued on every clock, and its result appears one cycle later with an output valid strobe. The unit sits in an execute stage. Decode, write-back and any status-flag accumulation belong to the surrounding pipeline.

Top module: `psat_unit`

## Requirements
- R1: With `op_sel` = 0 (byte mode), result bits [8k+7:8k] for k = 0..3 hold the signed sum of bits [8k+7:8k] of `src_a` and `src_b`. No carry crosses from one lane into the next.
- R2: In byte mode a lane sum above 127 gives 0x7F and a sum below -128 gives 0x80. `sat_flags[k]` is 1 exactly when lane k was clamped.
- R3: With `op_sel` = 1 (halfword mode), result bits [15:0] and [31:16] hold the signed sums of the matching halfwords of the sources. Each is clamped to the range -32768..32767 (0x8000..0x7FFF).
- R4: In halfword mode the clamp indicator of the low lane drives `sat_flags[1:0]` (both bits) and that of the high lane drives `sat_flags[3:2]` (both bits).
- R5: With `op_sel` = 2 (signed clamp), the result is `src_a` clamped to the range -2^(w-1)..2^(w-1)-1, where w is the effective width. `sat_flags[0]` is 1 when clamping occurred, `sat_flags[3:1]` are 0, and `src_b` has no effect.
- R6: With `op_sel` = 3 (unsigned clamp), the result is `src_a` clamped to the range 0..2^w-1. Every negative input therefore yields 0 with `sat_flags[0]` set, `sat_flags[3:1]` are 0, and `src_b` has no effect.
- R7: The effective width w equals `sat_width` for values 1..32. A `sat_width` of 0 acts as 1, and values 33..63 act as 32.
- R8: The result of an operation presented with `in_valid` high appears on `result`/`sat_flags` after the next rising edge, with `out_valid` high. A cycle with `in_valid` low makes `out_valid` low and leaves `result` and `sat_flags` unchanged.
- R9: While `rst_n` is low, `result`, `sat_flags` and `out_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 2 | 0 byte add, 1 halfword add, 2 signed clamp, 3 unsigned clamp |
| src_a | input | 32 | First source; the value to clamp in the clamp modes |
| src_b | input | 32 | Second source (add modes only) |
| sat_width | input | 6 | Clamp width for modes 2 and 3 |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Registered packed or clamped result |
| sat_flags | output | 4 | Registered per-lane clamp indicators |

## Verification
Boundary operands place each lane at its maximum, its minimum, one past the maximum and one below the minimum. This separates a correct clamp from an off-by-one limit or a wrapped sum. Random operands mix positive and negative lanes, so a carry leaking across a lane edge, or a flag routed to the wrong lane, corrupts a neighbour's expected value. Clamp modes are run with widths 1, 31 and 32 and with out-of-range width codes, which tells apart signed from unsigned limits and a mis-handled width code. A clamp is also repeated with a different second source, which shows that the second source is ignored.

// File: rtl/psat_pkg.sv
package psat_pkg;

    typedef enum logic [1:0] {
        OP_ADD8  = 2'd0,
        OP_ADD16 = 2'd1,
        OP_SATS  = 2'd2,
        OP_SATU  = 2'd3
    } op_e;

endpackage

// File: rtl/psat_lane_add.sv
module psat_lane_add #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] sum,
    output logic          sat
);
    localparam logic [LW-1:0] POS_LIM = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] NEG_LIM = {1'b1, {(LW-1){1'b0}}};

    logic [LW:0] wide;

    always_comb begin
        wide = {a[LW-1], a} + {b[LW-1], b};
        sat  = wide[LW] ^ wide[LW-1];
        if (!sat)
            sum = wide[LW-1:0];
        else if (wide[LW])
            sum = NEG_LIM;
        else
            sum = POS_LIM;
    end
endmodule

// File: rtl/psat_packed_add.sv
module psat_packed_add #(
    parameter int DW = 32,
    parameter int LW = 8
) (
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    output logic [DW-1:0]    sum,
    output logic [DW/LW-1:0] sat
);
    localparam int NL = DW / LW;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        psat_lane_add #(.LW(LW)) u_lane (
            .a   (a[k*LW +: LW]),
            .b   (b[k*LW +: LW]),
            .sum (sum[k*LW +: LW]),
            .sat (sat[k])
        );
    end
endmodule

// File: rtl/psat_width_clamp.sv
module psat_width_clamp #(
    parameter int DW = 32,
    parameter int WW = 6
) (
    input  logic [DW-1:0] value,
    input  logic [WW-1:0] width,
    input  logic          is_unsigned,
    output logic [DW-1:0] result,
    output logic          sat
);
    localparam int XW = DW + 2;
    localparam logic signed [XW-1:0] ONE = XW'(1);
    localparam logic [WW-1:0] WMAX = WW'(DW);

    logic [WW-1:0]          w_eff;
    logic signed [XW-1:0]   v_ext;
    logic signed [XW-1:0]   hi;
    logic signed [XW-1:0]   lo;
    logic signed [XW-1:0]   clamped;

    always_comb begin
        if (width == '0)
            w_eff = WW'(1);
        else if (width > WMAX)
            w_eff = WMAX;
        else
            w_eff = width;

        v_ext = {{2{value[DW-1]}}, value};

        if (is_unsigned) begin
            hi = (ONE <<< w_eff) - ONE;
            lo = '0;
        end else begin
            hi = (ONE <<< (w_eff - WW'(1))) - ONE;
            lo = -(ONE <<< (w_eff - WW'(1)));
        end

        if (v_ext > hi) begin
            clamped = hi;
            sat     = 1'b1;
        end else if (v_ext < lo) begin
            clamped = lo;
            sat     = 1'b1;
        end else begin
            clamped = v_ext;
            sat     = 1'b0;
        end
        result = clamped[DW-1:0];
    end
endmodule

// File: rtl/psat_unit.sv
module psat_unit
    import psat_pkg::*;
#(
    parameter int DW = 32,
    parameter int WW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    op_sel,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [WW-1:0] sat_width,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic [DW/8-1:0] sat_flags
);
    localparam int NF   = DW / 8;
    localparam int NL16 = DW / 16;

    op_e op;
    assign op = op_e'(op_sel);

    logic [DW-1:0]   sum8, sum16, clamp_res;
    logic [NF-1:0]   sat8, sat16_rep;
    logic [NL16-1:0] sat16;
    logic            clamp_sat;

    logic [DW-1:0]   next_res;
    logic [NF-1:0]   next_flags;

    psat_packed_add #(.DW(DW), .LW(8)) u_add8 (
        .a(src_a), .b(src_b), .sum(sum8), .sat(sat8)
    );

    psat_packed_add #(.DW(DW), .LW(16)) u_add16 (
        .a(src_a), .b(src_b), .sum(sum16), .sat(sat16)
    );

    psat_width_clamp #(.DW(DW), .WW(WW)) u_clamp (
        .value       (src_a),
        .width       (sat_width),
        .is_unsigned (op == OP_SATU),
        .result      (clamp_res),
        .sat         (clamp_sat)
    );

    for (genvar k = 0; k < NL16; k++) begin : g_rep
        assign sat16_rep[2*k +: 2] = {2{sat16[k]}};
    end

    always_comb begin
        unique case (op)
            OP_ADD8: begin
                next_res   = sum8;
                next_flags = sat8;
            end
            OP_ADD16: begin
                next_res   = sum16;
                next_flags = sat16_rep;
            end
            OP_SATS, OP_SATU: begin
                next_res   = clamp_res;
                next_flags = {{(NF-1){1'b0}}, clamp_sat};
            end
            default: begin
                next_res   = '0;
                next_flags = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= next_res;
                sat_flags <= next_flags;
            end
        end
    end
endmodule

// File: rtl/psat_unit_chk.sv
module psat_unit_chk #(
    parameter int DW = 32,
    parameter int WW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    op_sel,
    input logic [DW-1:0] src_a,
    input logic [DW-1:0] src_b,
    input logic [WW-1:0] sat_width,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic [DW/8-1:0] sat_flags
);
    localparam int NF = DW / 8;

    assert_issue_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(sat_flags)));

    for (genvar k = 0; k < NF; k++) begin : g_l8
        assert_lane8_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_sel == 2'd0) |=>
            (!sat_flags[k] || result[8*k +: 8] == 8'h7F || result[8*k +: 8] == 8'h80));
    end

    assert_pair_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd1) |=>
        (sat_flags[1] == sat_flags[0] && sat_flags[3] == sat_flags[2]));

    assert_clamp_upper_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[1]) |=> (sat_flags[NF-1:1] == '0));

    assert_neg_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd3 && src_a[DW-1]) |=> (result == '0 && sat_flags[0]));
endmodule

bind psat_unit psat_unit_chk #(.DW(DW), .WW(WW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .sat_width (sat_width),
    .out_valid (out_valid),
    .result    (result),
    .sat_flags (sat_flags)
);

// File: tb/sim_psat_unit.sv
module sim_psat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [5:0]  sat_width = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  sat_flags;

    always #4 clk = ~clk;

    psat_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .sat_width(sat_width),
        .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
    );

    typedef struct {
        logic [31:0] res;
        logic [3:0]  flg;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    function automatic exp_t model(input logic [1:0] op, input logic [31:0] a,
                                   input logic [31:0] b, input logic [5:0] w);
        exp_t e;
        e.res = '0;
        e.flg = '0;
        case (op)
            2'd0: begin
                e.tag = "R1";
                for (int k = 0; k < 4; k++) begin
                    int s;
                    s = int'($signed(a[8*k +: 8])) + int'($signed(b[8*k +: 8]));
                    if (s > 127) begin s = 127; e.flg[k] = 1'b1; end
                    else if (s < -128) begin s = -128; e.flg[k] = 1'b1; end
                    e.res[8*k +: 8] = 8'(s);
                end
                if (e.flg != 0) e.tag = "R2";
            end
            2'd1: begin
                e.tag = "R3";
                for (int k = 0; k < 2; k++) begin
                    int s;
                    s = int'($signed(a[16*k +: 16])) + int'($signed(b[16*k +: 16]));
                    if (s > 32767) begin s = 32767; e.flg[2*k +: 2] = 2'b11; end
                    else if (s < -32768) begin s = -32768; e.flg[2*k +: 2] = 2'b11; end
                    e.res[16*k +: 16] = 16'(s);
                end
                if (e.flg != 0) e.tag = "R4";
            end
            default: begin
                int     we;
                longint v, hi, lo, one;
                one = 1;
                we = (w == 0) ? 1 : ((w > 32) ? 32 : int'(w));
                v  = longint'($signed(a));
                if (op == 2'd3) begin
                    hi = (one << we) - 1;
                    lo = 0;
                    e.tag = "R6";
                end else begin
                    hi = (one << (we - 1)) - 1;
                    lo = -(one << (we - 1));
                    e.tag = "R5";
                end
                if (v > hi) begin v = hi; e.flg[0] = 1'b1; end
                else if (v < lo) begin v = lo; e.flg[0] = 1'b1; end
                e.res = 32'(v);
                if (w == 0 || w > 32) e.tag = "R7";
            end
        endcase
        return e;
    endfunction

    task automatic issue(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [5:0] w);
        @(negedge clk);
        op_sel    = op;
        src_a     = a;
        src_b     = b;
        sat_width = w;
        in_valid  = 1'b1;
        exp_q.push_back(model(op, a, b, w));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected out_valid, result %h", result);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (result !== e.res || sat_flags !== e.flg) begin
                    errors++;
                    $display("FAIL %s: result %h flags %b, expected %h %b",
                             e.tag, result, sat_flags, e.res, e.flg);
                end
            end
        end
    end

    task automatic boundary(input logic [1:0] op);
        logic [31:0] mx, mn, one, neg1;
        if (op == 2'd0) begin
            mx = 32'h7F7F7F7F; mn = 32'h80808080; one = 32'h01010101;
        end else begin
            mx = 32'h7FFF7FFF; mn = 32'h80008000; one = 32'h00010001;
        end
        neg1 = 32'hFFFFFFFF;
        issue(op, mx, '0, 6'd0);     // at maximum
        issue(op, mn, '0, 6'd0);     // at minimum
        issue(op, mx, one, 6'd0);    // maximum + 1
        issue(op, mn, neg1, 6'd0);   // minimum - 1
        issue(op, mx, mx, 6'd0);
        issue(op, mn, mn, 6'd0);
        issue(op, mx, mn, 6'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_r;
        logic [3:0]  held_f;

        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || sat_flags !== '0) begin
            errors++;
            $display("FAIL R9: valid %b result %h flags %b, expected 0 0 0",
                     out_valid, result, sat_flags);
        end
        rst_n = 1'b1;

        // R1/R2 and R3/R4 boundaries, mixed-sign lanes
        boundary(2'd0);
        boundary(2'd1);
        issue(2'd0, 32'h7F80017F, 32'h01FFFF80, 6'd0);
        issue(2'd0, 32'h00FF00FF, 32'h00010001, 6'd0);  // carry isolation R1
        issue(2'd1, 32'h7FFF8000, 32'h0001FFFF, 6'd0);
        issue(2'd1, 32'h0000FFFF, 32'h00000001, 6'd0);  // carry isolation R3

        // R5/R6/R7 widths
        for (int w = 0; w < 64; w += 7) begin
            issue(2'd2, 32'h12345678, '0, 6'(w));
            issue(2'd2, 32'h87654321, '0, 6'(w));
            issue(2'd3, 32'h12345678, '0, 6'(w));
            issue(2'd3, 32'hFFFFFF00, '0, 6'(w));
        end
        issue(2'd2, 32'h80000000, '0, 6'd32);
        issue(2'd2, 32'h00000001, '0, 6'd1);
        issue(2'd2, 32'hFFFFFFFF, '0, 6'd1);
        issue(2'd3, 32'hFFFFFFFF, '0, 6'd32);
        issue(2'd3, 32'h7FFFFFFF, '0, 6'd31);
        issue(2'd3, 32'h00000002, '0, 6'd0);
        issue(2'd2, 32'h000000FF, '0, 6'd40);
        // R5/R6: src_b has no effect
        issue(2'd2, 32'h00001000, 32'hDEADBEEF, 6'd8);
        issue(2'd2, 32'h00001000, 32'h00000000, 6'd8);
        issue(2'd3, 32'h0000007F, 32'h7FFFFFFF, 6'd4);

        // random vectors across all modes
        for (int i = 0; i < 800; i++) begin
            issue(2'(i % 4), $urandom, $urandom, 6'($urandom_range(0, 63)));
        end

        // R8: hold when idle
        issue(2'd0, 32'h7F7F7F7F, 32'h7F7F7F7F, 6'd0);
        idle();
        @(negedge clk);
        held_r = result;
        held_f = sat_flags;
        src_a = 32'h01010101;
        src_b = 32'h01010101;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== held_r || sat_flags !== held_f) begin
            errors++;
            $display("FAIL R8: valid %b result %h flags %b, expected 0 %h %b",
                     out_valid, result, sat_flags, held_r, held_f);
        end

        // R8: back-to-back issue drains fully
        issue(2'd1, 32'h00010002, 32'h00030004, 6'd0);
        issue(2'd1, 32'h00050006, 32'h00070008, 6'd0);
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule